// File: doc/BRIEF.md
# Multi-Channel Compare-Match Periodic Timer

A memory-mapped timer unit with several identical channels. Each channel holds a 16-bit up-counter fed by a selectable prescaler and compared against a compare register. When the counter equals the compare value on a prescaled tick, the channel raises a status flag. If clear-on-compare is selected, the counter also returns to zero, which gives a periodic event every (compare + 1) prescaled ticks. The flag drives the channel's interrupt output when its enable bit is set.

A single shared byte-wide start register holds one run bit per channel. Software acknowledges an event with a read of the status byte that finds the flag set, followed by a write with bit 0 at zero. The bus port is a flat register interface with a byte or halfword size per access. Reads return data combinationally from the address and size. Read side effects occur only on a request cycle.

Top module: `cmt_timer`

## Requirements
- R1: After reset every channel's control, mode, I/O-control, interrupt-enable, status and counter read 0, its compare register reads 0xFFFF, the start register reads 0, and no interrupt is asserted.
- R2: Channel c is mapped at byte address 16*c. Its byte registers are control (+0), mode (+1), I/O control (+2), interrupt enable (+4) and status (+5). Its halfword registers are counter (+6) and compare (+8). `size_i`=0 selects a byte and `size_i`=1 a halfword. An access of the wrong size to a register writes nothing and reads 0.
- R3: The start register is a byte at address 0xF0. Bit c is channel c's run bit, and bits at or above the channel count read 0. A channel whose run bit is clear holds its counter, and the run bits of other channels have no effect on it.
- R4: With prescale code 0, a running channel's counter increments on every clock edge after the edge that sets its run bit, up to and including the edge that clears it.
- R5: Control bits [1:0] select a divide by 1, 4, 16 or 64, and bit 2 is ignored. The prescaler restarts from zero whenever the channel is stopped, so the first count after a start lands 4^code edges after it.
- R6: When control bits [7:5] equal 1 and the counter equals compare on a tick, the counter goes to 0 on that tick and the flag (status bit 0) sets. The period is therefore compare+1 ticks.
- R7: `irq_o[c]` is high exactly when channel c's flag is set and bit 0 of its interrupt-enable register is 1.
- R8: A status write with bit 0 at 0 clears the flag only if a status read with the flag at 1 happened since the previous status write. A match on the same tick as the clear keeps the flag set.
- R9: A halfword write to the counter loads the written value, overriding a count in the same cycle.
- R10: A nonzero mode value holds the counter even while the channel runs.
- R11: With any clear-source code other than 1, the counter runs past a match without clearing, and the flag still sets on the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 1 | 0 = byte, 1 = halfword |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 16 | Write data; bytes use bits [7:0] |
| rdata_o | output | 16 | Read data for addr_i/size_i |
| irq_o | output | 3 | Per-channel interrupt |

## Verification
A wrong counter or prescaler state shows up at the first readback of the counter after a stop. It also moves the edge at which `irq_o` rises, and that shift is visible within one period of compare+1 ticks. A wrong armed state for the flag appears on the next status write: the flag and `irq_o` either drop when they should hold, or hold when they should drop. A fault in start-bit routing shows up as a nonzero count in a channel that was never started.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam logic [3:0] OFF_CTRL = 4'd0;
  localparam logic [3:0] OFF_MODE = 4'd1;
  localparam logic [3:0] OFF_IOC  = 4'd2;
  localparam logic [3:0] OFF_IEN  = 4'd4;
  localparam logic [3:0] OFF_STAT = 4'd5;
  localparam logic [3:0] OFF_CNT  = 4'd6;
  localparam logic [3:0] OFF_CMP  = 4'd8;
  localparam logic [2:0] CLR_SRC_CMP = 3'd1;
  localparam int unsigned PS_CODES = 4;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int unsigned PS_W = 2 * (cmt_pkg::PS_CODES - 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] code_i,
  output logic       tick_o
);
  logic [PS_W-1:0] pcnt_q;
  logic [PS_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PS_W; i++) mask[i] = (i < 2 * int'(code_i));
  end

  assign tick_o = run_i && ((pcnt_q & mask) == mask);

  // stopped channel restarts its prescale phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pcnt_q <= '0;
    else if (!run_i) pcnt_q <= '0;
    else             pcnt_q <= pcnt_q + 1'b1;
  end

  // R5
  div1_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && code_i == 2'd0) |-> tick_o);
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel import cmt_pkg::*; #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             acc_i,
  input  logic             we_i,
  input  logic             size_i,
  input  logic [3:0]       off_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o
);
  logic [7:0]       ctrl_q, mode_q, ioc_q, ien_q;
  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic             flag_q, armed_q;
  logic             tick, count_en, match, clr_cmp;
  logic             byte_wr, half_wr, wr_cnt, wr_stat, rd_stat;

  assign byte_wr = acc_i && we_i && !size_i;
  assign half_wr = acc_i && we_i && size_i;
  assign wr_cnt  = half_wr && off_i == OFF_CNT;
  assign wr_stat = byte_wr && off_i == OFF_STAT;
  assign rd_stat = acc_i && !we_i && !size_i && off_i == OFF_STAT;

  cmt_prescaler u_ps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .code_i (ctrl_q[1:0]),
    .tick_o (tick)
  );

  assign count_en = tick && (mode_q == 8'd0);
  assign match    = (cnt_q == cmp_q);
  assign clr_cmp  = (ctrl_q[7:5] == CLR_SRC_CMP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mode_q <= '0;
      ioc_q  <= '0;
      ien_q  <= '0;
      cmp_q  <= '1;
    end else begin
      if (byte_wr && off_i == OFF_CTRL) ctrl_q <= wdata_i[7:0];
      if (byte_wr && off_i == OFF_MODE) mode_q <= wdata_i[7:0];
      if (byte_wr && off_i == OFF_IOC)  ioc_q  <= wdata_i[7:0];
      if (byte_wr && off_i == OFF_IEN)  ien_q  <= wdata_i[7:0];
      if (half_wr && off_i == OFF_CMP)  cmp_q  <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (wr_cnt)   cnt_q <= wdata_i;
    else if (count_en) cnt_q <= (match && clr_cmp) ? '0 : cnt_q + 1'b1;
  end

  // flag clears only after a read that saw it set; a fresh match wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q <= (count_en && match) ||
                (flag_q && !(wr_stat && !wdata_i[0] && armed_q));
      if (wr_stat)                armed_q <= 1'b0;
      else if (rd_stat && flag_q) armed_q <= 1'b1;
    end
  end

  assign irq_o = flag_q && ien_q[0];

  always_comb begin
    rdata_o = '0;
    if (!size_i) begin
      unique case (off_i)
        OFF_CTRL: rdata_o = {{(CNT_W-8){1'b0}}, ctrl_q};
        OFF_MODE: rdata_o = {{(CNT_W-8){1'b0}}, mode_q};
        OFF_IOC:  rdata_o = {{(CNT_W-8){1'b0}}, ioc_q};
        OFF_IEN:  rdata_o = {{(CNT_W-8){1'b0}}, ien_q};
        OFF_STAT: rdata_o = {{(CNT_W-1){1'b0}}, flag_q};
        default:  rdata_o = '0;
      endcase
    end else begin
      unique case (off_i)
        OFF_CNT: rdata_o = cnt_q;
        OFF_CMP: rdata_o = cmp_q;
        default: rdata_o = '0;
      endcase
    end
  end

  // R6
  clr_on_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_en && match && clr_cmp && !wr_cnt) |=> (cnt_q == '0 && flag_q));
  // R8
  flag_needs_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(armed_q));
  // R9
  cnt_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt |=> (cnt_q == $past(wdata_i)));
  // R3
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_cnt) |=> (cnt_q == $past(cnt_q)));
  // R10
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != 8'd0 && !wr_cnt) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer #(
  parameter int unsigned N_CH       = 3,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned CNT_W      = 16,
  parameter logic [ADDR_W-1:0] START_ADDR = 8'hF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [N_CH-1:0]   irq_o
);
  localparam int unsigned CH_W = ADDR_W - 4;

  logic [N_CH-1:0]  run_q;
  logic [N_CH-1:0]  ch_sel;
  logic [CNT_W-1:0] ch_rd [N_CH];
  logic             start_hit;

  assign start_hit = (addr_i == START_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (req_i && we_i && !size_i && start_hit) run_q <= wdata_i[N_CH-1:0];
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign ch_sel[c] = !start_hit && (addr_i[ADDR_W-1:4] == CH_W'(c));
    cmt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (run_q[c]),
      .acc_i   (req_i && ch_sel[c]),
      .we_i    (we_i),
      .size_i  (size_i),
      .off_i   (addr_i[3:0]),
      .wdata_i (wdata_i),
      .rdata_o (ch_rd[c]),
      .irq_o   (irq_o[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (start_hit) begin
      if (!size_i) rdata_o = {{(CNT_W-N_CH){1'b0}}, run_q};
    end else begin
      for (int c = 0; c < N_CH; c++) if (ch_sel[c]) rdata_o = ch_rd[c];
    end
  end
endmodule

// File: tb/cmt_timer_test.sv
module cmt_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, size = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  irq;
  int errors = 0, checks = 0;
  logic [15:0] d;

  always #4 clk = ~clk;

  cmt_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  localparam logic [7:0] ST = 8'hF0;
  function automatic logic [7:0] ra(int ch, int off);
    return 8'(ch * 16 + off);
  endfunction

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic s, logic [15:0] v);
    @(negedge clk);
    req = 1; we = 1; size = s; addr = a; wdata = v;
    @(posedge clk); #1;
    req = 0; we = 0;
  endtask

  task automatic rd(logic [7:0] a, logic s, output logic [15:0] v);
    @(negedge clk);
    req = 1; we = 0; size = s; addr = a;
    #1 v = rdata;
    @(posedge clk); #1;
    req = 0;
  endtask

  task automatic peek(logic [7:0] a, logic s, output logic [15:0] v);
    addr = a; size = s; req = 0;
    #1 v = rdata;
  endtask

  task automatic t_reset;
    peek(ra(0,0), 0, d); chk("R1 ctrl", d, 0);
    peek(ra(2,4), 0, d); chk("R1 ien", d, 0);
    peek(ra(1,5), 0, d); chk("R1 status", d, 0);
    peek(ra(0,6), 1, d); chk("R1 counter", d, 0);
    peek(ra(0,8), 1, d); chk("R1 compare", d, 16'hFFFF);
    peek(ST, 0, d);      chk("R1 start", d, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_regs;
    wr(ra(1,2), 0, 16'h005A); peek(ra(1,2), 0, d); chk("R2 ioc", d, 16'h5A);
    wr(ra(1,4), 0, 16'h0001); peek(ra(1,4), 0, d); chk("R2 ien", d, 1);
    wr(ra(1,8), 1, 16'h1234); peek(ra(1,8), 1, d); chk("R2 compare", d, 16'h1234);
    wr(ra(1,6), 0, 16'h0055); peek(ra(1,6), 1, d); chk("R2 byte to counter ignored", d, 0);
    wr(ra(1,0), 1, 16'h0023); peek(ra(1,0), 0, d); chk("R2 halfword to ctrl ignored", d, 0);
    peek(ra(1,2), 1, d); chk("R2 halfword read of byte reg", d, 0);
    wr(ra(1,4), 0, 16'h0000);
    wr(ST, 0, 16'h00F8); peek(ST, 0, d); chk("R3 start upper bits", d, 0);
  endtask

  task automatic t_start;
    wr(ST, 0, 16'h0001);
    repeat (6) @(posedge clk);
    wr(ST, 0, 16'h0000);
    peek(ra(0,6), 1, d); chk("R4 div1 count", d, 7);
    peek(ra(1,6), 1, d); chk("R3 other channel idle", d, 0);
  endtask

  task automatic run_for(int ch, int k);
    wr(ST, 0, 16'(1 << ch));
    repeat (k) @(posedge clk);
    wr(ST, 0, 16'h0000);
  endtask

  task automatic t_prescale;
    wr(ra(0,6), 1, 0); wr(ra(0,0), 0, 16'h01);
    run_for(0, 9);  peek(ra(0,6), 1, d); chk("R5 div4", d, 2);
    run_for(0, 2);  peek(ra(0,6), 1, d); chk("R5 prescaler restart", d, 2);
    wr(ra(0,6), 1, 0); wr(ra(0,0), 0, 16'h02);
    run_for(0, 47); peek(ra(0,6), 1, d); chk("R5 div16", d, 3);
    wr(ra(0,6), 1, 0); wr(ra(0,0), 0, 16'h03);
    run_for(0, 127); peek(ra(0,6), 1, d); chk("R5 div64", d, 2);
    wr(ra(0,6), 1, 0); wr(ra(0,0), 0, 16'h07);
    run_for(0, 63); peek(ra(0,6), 1, d); chk("R5 bit2 ignored", d, 1);
  endtask

  task automatic t_period;
    wr(ra(0,6), 1, 0); wr(ra(0,0), 0, 16'h20);
    wr(ra(0,8), 1, 16'd4); wr(ra(0,4), 0, 16'h01);
    wr(ST, 0, 16'h0001);
    repeat (4) @(posedge clk); #1;
    peek(ra(0,6), 1, d); chk("R6 count at compare", d, 4);
    chk("R7 irq before match", irq[0], 0);
    @(posedge clk); #1;
    peek(ra(0,6), 1, d); chk("R6 cleared on match", d, 0);
    chk("R7 irq on match", irq[0], 1);
    repeat (4) @(posedge clk); #1;
    peek(ra(0,6), 1, d); chk("R6 second period", d, 4);
    wr(ST, 0, 16'h0000);
    peek(ra(0,6), 1, d); chk("R6 period wrap", d, 0);
    wr(ra(0,4), 0, 16'h00); chk("R7 irq masked", irq[0], 0);
    wr(ra(0,4), 0, 16'h01); chk("R7 irq unmasked", irq[0], 1);
  endtask

  task automatic t_flag;
    wr(ra(0,5), 0, 16'hFE);
    peek(ra(0,5), 0, d); chk("R8 clear without read ignored", d, 1);
    chk("R8 irq held", irq[0], 1);
    rd(ra(0,5), 0, d); chk("R8 read sees flag", d, 1);
    wr(ra(0,5), 0, 16'hFE);
    peek(ra(0,5), 0, d); chk("R8 cleared after read", d, 0);
    chk("R8 irq dropped", irq[0], 0);
  endtask

  task automatic t_cnt_write;
    wr(ra(0,0), 0, 16'h00); wr(ra(0,8), 1, 16'hFFFF); wr(ra(0,4), 0, 0);
    wr(ST, 0, 16'h0001);
    repeat (3) @(posedge clk);
    wr(ra(0,6), 1, 16'h1234);
    peek(ra(0,6), 1, d); chk("R9 write beats count", d, 16'h1234);
    @(posedge clk); #1;
    peek(ra(0,6), 1, d); chk("R9 counts on from written", d, 16'h1235);
    wr(ST, 0, 16'h0000);
  endtask

  task automatic t_mode;
    wr(ra(1,6), 1, 0); wr(ra(1,1), 0, 16'h01);
    run_for(1, 5);
    peek(ra(1,6), 1, d); chk("R10 nonzero mode holds", d, 0);
    wr(ra(1,1), 0, 16'h00);
    run_for(1, 1);
    peek(ra(1,6), 1, d); chk("R10 mode zero counts", d, 2);
  endtask

  task automatic t_free;
    wr(ra(2,0), 0, 16'h00); wr(ra(2,8), 1, 16'd2); wr(ra(2,6), 1, 0);
    run_for(2, 4);
    peek(ra(2,6), 1, d); chk("R11 no clear on match", d, 5);
    peek(ra(2,5), 0, d); chk("R11 flag still set", d, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_regs();
    t_start();
    t_prescale();
    t_period();
    t_flag();
    t_cnt_write();
    t_mode();
    t_free();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule